// File: doc/BRIEF.md
# Burst Address Sequencer

The block turns one start address into a short burst of up to four addresses. A load stores the full start address and the read/write direction. Each later advance moves a two-bit beat counter one step. Only the two lowest address bits change during a burst. They come from the start bits and the beat count, in one of two orders. Linear order adds the beat count to the start bits, wrapping within the group of four. Interleaved order XORs the beat count into the start bits. The upper address bits keep their loaded value.

Advancing does not depend on any select or write signal. The direction captured at the load is held for the whole burst. An active-low clock enable qualifies every edge. When the enable is inactive, all state is frozen. The outputs are decoded from state without an extra register, so they change in the cycle after the edge that loads or advances.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, addr_o is 0 and we_o is 0.
- R2: At a rising edge with cen_ni = 0 and adv_ld_i = 0, the block loads a new burst. After that edge, addr_o equals the sampled addr_i and we_o equals the sampled we_i. The beat count restarts at 0.
- R3: With ord_i = 0 (linear), addr_o[1:0] = (start[1:0] + beats) mod 4. Here beats is the number of qualified advances since the load, taken mod 4.
- R4: With ord_i = 1 (interleaved), addr_o[1:0] = start[1:0] XOR beats.
- R5: Bits addr_o[ADDR_W-1:2] keep their loaded value through every advance.
- R6: After four advances, addr_o returns to the start address in either order.
- R7: At an edge with cen_ni = 0 and adv_ld_i = 1, we_o keeps its value, whatever we_i holds. The edge still advances the beat count, whatever we_i holds.
- R8: At an edge with cen_ni = 1, no state changes, whatever adv_ld_i, addr_i and we_i hold.
- R9: ord_i acts on addr_o at once, without a clock edge. Switching it mid-burst re-maps the current beat without changing the stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cen_ni | input | 1 | Clock enable, active low |
| adv_ld_i | input | 1 | 0 = load a new address, 1 = advance the burst |
| ord_i | input | 1 | Burst order: 0 = linear, 1 = interleaved |
| addr_i | input | ADDR_W | Start address sampled at a load |
| we_i | input | 1 | Direction sampled at a load: 1 = write |
| addr_o | output | ADDR_W | Current burst address |
| we_o | output | 1 | Direction latched at the last load |

## Verification
A corrupted beat counter shows on addr_o[1:0] one cycle after the faulty edge. It shows as a skipped beat, a missing wrap or a wrong order. A bad start register shows in the upper bits or on we_o in the cycle after a load or an advance. A missed enable qualification shows as an address change after a frozen edge. Every start offset is walked in both orders past the wrap, and random stimulus compares each cycle against a model.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int unsigned BEAT_W = 2;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         clr_i,
  output logic [W-1:0] beat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     beat_o <= '0;
    else if (en_i) begin
      if (clr_i)     beat_o <= '0;
      else           beat_o <= beat_o + W'(1); // wraps mod 2^W
    end
  end
endmodule

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output logic [ADDR_W-1:0] base_o,
  output logic              we_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      we_o   <= 1'b0;
    end else if (en_i && load_i) begin
      base_o <= addr_i;
      we_o   <= we_i;
    end
  end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int unsigned W = BEAT_W
) (
  input  logic [W-1:0] start_i,
  input  logic [W-1:0] beat_i,
  input  burst_order_e ord_i,
  output logic [W-1:0] low_o
);
  logic [W-1:0] lin_w;
  logic [W-1:0] ilv_w;

  assign lin_w = start_i + beat_i;

  for (genvar b = 0; b < W; b++) begin : g_ilv
    assign ilv_w[b] = start_i[b] ^ beat_i[b];
  end

  always_comb begin
    unique case (ord_i)
      ORD_INTERLEAVE: low_o = ilv_w;
      default:        low_o = lin_w;
    endcase
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cen_ni,
  input  logic              adv_ld_i,
  input  logic              ord_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o
);
  localparam int unsigned UP_W = ADDR_W - BEAT_W;

  logic              qual_w;
  logic              load_w;
  logic [BEAT_W-1:0] beat_q;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] low_w;
  burst_order_e      ord_w;

  assign qual_w = ~cen_ni;
  assign load_w = ~adv_ld_i;
  assign ord_w  = burst_order_e'(ord_i);

  burst_beat_ctr #(.W(BEAT_W)) u_beat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (qual_w),
    .clr_i  (load_w),
    .beat_o (beat_q)
  );

  burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (qual_w),
    .load_i (load_w),
    .addr_i (addr_i),
    .we_i   (we_i),
    .base_o (base_q),
    .we_o   (we_o)
  );

  burst_order_map #(.W(BEAT_W)) u_map (
    .start_i (base_q[BEAT_W-1:0]),
    .beat_i  (beat_q),
    .ord_i   (ord_w),
    .low_o   (low_w)
  );

  assign addr_o = {base_q[ADDR_W-1 -: UP_W], low_w};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cen_ni,
  input logic              adv_ld_i,
  input logic              ord_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              we_o
);
  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && !adv_ld_i) |=> (addr_o == $past(addr_i) && we_o == $past(we_i)));

  p_lin_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && adv_ld_i && !ord_i) |=> (!ord_i -> addr_o[1:0] == $past(addr_o[1:0]) + 2'd1));

  p_upper_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && adv_ld_i) |=> (addr_o[ADDR_W-1:2] == $past(addr_o[ADDR_W-1:2])));

  p_dir_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && adv_ld_i) |=> $stable(we_o));

  p_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cen_ni |=> ($stable(we_o) && ($stable(ord_i) -> $stable(addr_o))));

  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (addr_o == '0 && !we_o));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cen_ni   (cen_ni),
  .adv_ld_i (adv_ld_i),
  .ord_i    (ord_i),
  .addr_i   (addr_i),
  .we_i     (we_i),
  .addr_o   (addr_o),
  .we_o     (we_o)
);

// File: tb/burst_addr_gen_test.sv
`timescale 1ns/1ps
module burst_addr_gen_test;
  localparam int unsigned AW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cen_ni = 1'b1;
  logic          adv_ld_i = 1'b1;
  logic          ord_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          we_i = 1'b0;
  logic [AW-1:0] addr_o;
  logic          we_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_beat = '0;
  logic          m_we = 1'b0;

  always #5 clk_i = ~clk_i;

  burst_addr_gen #(.ADDR_W(AW)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cen_ni(cen_ni), .adv_ld_i(adv_ld_i),
    .ord_i(ord_i), .addr_i(addr_i), .we_i(we_i), .addr_o(addr_o), .we_o(we_o)
  );

  function automatic logic [1:0] exp_low(logic [1:0] s, logic [1:0] b, logic o);
    int v;
    if (o) v = {30'd0, s} ^ {30'd0, b};
    else   v = ({30'd0, s} + {30'd0, b}) % 4;
    return v[1:0];
  endfunction

  function automatic logic [AW-1:0] exp_addr(logic o);
    return {m_base[AW-1:2], exp_low(m_base[1:0], m_beat, o)};
  endfunction

  task automatic check(string req, logic [AW-1:0] ea, logic ew);
    n_chk++;
    if (addr_o !== ea || we_o !== ew) begin
      n_bad++;
      $display("FAIL %s: addr_o=%h we_o=%b expected addr_o=%h we_o=%b", req, addr_o, we_o, ea, ew);
    end
  endtask

  // drive at negedge, clock one edge, update model, check at next negedge
  task automatic step(logic cen, logic adv, logic o, logic [AW-1:0] a, logic w, string req);
    cen_ni = cen; adv_ld_i = adv; ord_i = o; addr_i = a; we_i = w;
    @(posedge clk_i);
    if (!cen) begin
      if (!adv) begin m_base = a; m_beat = 2'd0; m_we = w; end
      else m_beat = m_beat + 2'd1;
    end
    @(negedge clk_i);
    check(req, exp_addr(o), m_we);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    check("R1", '0, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", '0, 1'b0);

    // every start offset, both orders, through the wrap
    for (int o = 0; o < 2; o++) begin
      for (int s = 0; s < 4; s++) begin
        logic [AW-1:0] a;
        a = {14'h2a5 + 14'(s), 2'(s)};
        step(1'b0, 1'b0, o[0], a, s[0], "R2");
        for (int k = 1; k <= 3; k++)
          step(1'b0, 1'b1, o[0], '1, ~s[0], (o == 0) ? "R3" : "R4");
        step(1'b0, 1'b1, o[0], '0, ~s[0], "R6");
        check("R6", a, s[0]);
        step(1'b0, 1'b1, o[0], '0, s[0], "R5");
      end
    end

    // direction held while we_i toggles
    step(1'b0, 1'b0, 1'b0, 16'h1232, 1'b1, "R2");
    step(1'b0, 1'b1, 1'b0, 16'hffff, 1'b0, "R7");
    step(1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, "R7");
    check("R7", 16'h1230, 1'b1);

    // frozen edges: load attempt and advance attempt both ignored
    step(1'b1, 1'b0, 1'b0, 16'hbeef, 1'b0, "R8");
    check("R8", 16'h1230, 1'b1);
    step(1'b1, 1'b1, 1'b0, 16'h0000, 1'b0, "R8");
    check("R8", 16'h1230, 1'b1);

    // order switched mid-burst without an edge
    step(1'b0, 1'b0, 1'b0, 16'h4441, 1'b0, "R2");
    step(1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, "R3");
    step(1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, "R3");
    check("R3", 16'h4443, 1'b0);
    ord_i = 1'b1;
    #1;
    check("R9", 16'h4443, 1'b0);
    ord_i = 1'b0;
    step(1'b0, 1'b1, 1'b1, 16'h0000, 1'b0, "R4");
    check("R9", 16'h4442, 1'b0);

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic c, a, o, w;
      logic [AW-1:0] ad;
      c  = ($urandom % 5) == 0;
      a  = ($urandom % 4) != 0;
      o  = ($urandom % 8) == 0 ? ~ord_i : ord_i;
      w  = 1'($urandom);
      ad = AW'($urandom);
      step(c, a, o, ad, w, "R3/R4/R8 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule